// File: doc/BRIEF.md
# Multicycle Control State Sequencer

This block is the state controller of a small 8-bit accumulator machine. Each instruction is walked through three fetch steps and three execute steps. Non-memory instructions always take all three execute steps, even when some of them do no work. For memory-reference instructions, a 2-bit addressing-case code can insert either a two-step or a four-step indirect-address phase between fetch and execute. The block reports its current step on eleven step lines. Exactly one line is high for the whole period between two clock edges, so the datapath can gate its register loads directly from those lines.

After reset the controller waits in the idle step until the run request is raised. At the end of each instruction it starts the next fetch if the run request is still high, and otherwise it returns to idle. The addressing-case code is taken from the decoded instruction. It is sampled once, in the last fetch step. The choice between the short and the long indirect path is then held internally, so later changes on the code pins cannot alter the path already under way. The step is kept in a 4-bit binary register and decoded to the lines. Any unused encoding falls back to idle on the next edge. Step line bit positions are: 0 idle, 1 fetch-1, 2 fetch-2, 3 fetch-3, 4 exec-1, 5 exec-2, 6 exec-3, 7 ind-1, 8 ind-2, 9 ind-3, 10 ind-4.

Top module: `ctl_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, the next step is idle (`state_line` = bit 0 only), whatever `run_req` and `addr_case` are.
- R2: Out of reset, `state_line` has exactly one bit set in every clock period.
- R3: Fetch-1 always goes to fetch-2, and fetch-2 always goes to fetch-3; `run_req` and `addr_case` have no effect on these steps.
- R4: In fetch-3 with `addr_case` = 2'b00, the next step is exec-1.
- R5: In fetch-3 with `addr_case` = 2'b01, the path is ind-1, ind-2, then exec-1.
- R6: In fetch-3 with `addr_case` = 2'b10, the path is ind-1, ind-2, ind-3, ind-4, then exec-1.
- R7: `addr_case` = 2'b11 in fetch-3 behaves exactly like 2'b00 (straight to exec-1).
- R8: Exec-1 always goes to exec-2, and exec-2 always goes to exec-3; the inputs have no effect on these steps.
- R9: After exec-3 the next step is fetch-1 if `run_req` is high, and idle if it is low.
- R10: In idle, the controller stays in idle while `run_req` is low and moves to fetch-1 when it is high.
- R11: `addr_case` is sampled only in fetch-3. Its value during the indirect steps does not change the path chosen in fetch-3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| run_req | input | 1 | Run request; releases idle and continues after exec-3 |
| addr_case | input | 2 | Addressing-case code from the decoded instruction |
| state_line | output | 11 | One-hot current-step lines, bit map as above |

## Verification
The bench builds the block with its package defaults: a 4-bit step code and eleven step lines. With these values, all eleven steps and all five unused codes of the register lie within one decoder. Random `addr_case` values on every cycle, with `addr_case` changing during the indirect steps, exercise the latched path choice. A sparse low `run_req` drives the exits from exec-3 to idle and the waits in idle. Occasional resets in the middle of an instruction check recovery from any step.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int STATE_W    = 4;
  localparam int NUM_STATES = 11;
  localparam int CASE_W     = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 4'd0,
    ST_F1   = 4'd1,
    ST_F2   = 4'd2,
    ST_F3   = 4'd3,
    ST_E1   = 4'd4,
    ST_E2   = 4'd5,
    ST_E3   = 4'd6,
    ST_I1   = 4'd7,
    ST_I2   = 4'd8,
    ST_I3   = 4'd9,
    ST_I4   = 4'd10
  } seq_state_e;

  localparam logic [CASE_W-1:0] CASE_ONE_STEP = 2'b01;
  localparam logic [CASE_W-1:0] CASE_TWO_STEP = 2'b10;
endpackage

// File: rtl/ctl_seq_next.sv
module ctl_seq_next
  import ctl_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  logic              long_q,
  input  logic              run_req,
  input  logic [CASE_W-1:0] addr_case,
  output seq_state_e        state_d,
  output logic              long_d
);
  logic case_ind;

  assign case_ind = (addr_case == CASE_ONE_STEP) || (addr_case == CASE_TWO_STEP);

  always_comb begin
    long_d = long_q;
    if (state_q == ST_F3) long_d = (addr_case == CASE_TWO_STEP);
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: state_d = run_req ? ST_F1 : ST_IDLE;
      ST_F1:   state_d = ST_F2;
      ST_F2:   state_d = ST_F3;
      ST_F3:   state_d = case_ind ? ST_I1 : ST_E1;
      ST_I1:   state_d = ST_I2;
      ST_I2:   state_d = long_q ? ST_I3 : ST_E1;
      ST_I3:   state_d = ST_I4;
      ST_I4:   state_d = ST_E1;
      ST_E1:   state_d = ST_E2;
      ST_E2:   state_d = ST_E3;
      ST_E3:   state_d = run_req ? ST_F1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // R10: idle holds without a run request
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !run_req) |=> (state_q == ST_IDLE));

  // R4 and R7: cases 00 and 11 go straight to exec-1
  assert_direct_exec_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_F3 && addr_case[1] == addr_case[0]) |=> (state_q == ST_E1));

  // R8: execute steps advance unconditionally
  assert_exec_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_E1) |=> (state_q == ST_E2));

  // R9: the end of an instruction without a run request returns to idle
  assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_E3 && !run_req) |=> (state_q == ST_IDLE));

  // R11: a two-step case sampled in fetch-3 leads to ind-3 after ind-2
  assert_long_path_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_F3 && addr_case == CASE_TWO_STEP) |=> ##1 ##1 (state_q == ST_I3));
endmodule

// File: rtl/ctl_seq_reg.sv
module ctl_seq_reg
  import ctl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d,
  input  logic       long_d,
  output seq_state_e state_q,
  output logic       long_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      long_q  <= long_d;
    end
  end
endmodule

// File: rtl/ctl_seq_decode.sv
module ctl_seq_decode #(
  parameter int STATE_W   = 4,
  parameter int NUM_LINES = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STATE_W-1:0]   code,
  output logic [NUM_LINES-1:0] lines
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lines[g] = (code == STATE_W'(g));
  end

  // R2: exactly one line is high in each period
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(lines) == 1);
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_req,
  input  logic [CASE_W-1:0]     addr_case,
  output logic [NUM_STATES-1:0] state_line
);
  seq_state_e state_q;
  seq_state_e state_d;
  logic       long_q;
  logic       long_d;

  ctl_seq_next i_next (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .long_q    (long_q),
    .run_req   (run_req),
    .addr_case (addr_case),
    .state_d   (state_d),
    .long_d    (long_d)
  );

  ctl_seq_reg i_reg (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .long_d  (long_d),
    .state_q (state_q),
    .long_q  (long_q)
  );

  ctl_seq_decode #(
    .STATE_W   (STATE_W),
    .NUM_LINES (NUM_STATES)
  ) i_decode (
    .clk   (clk),
    .rst   (rst),
    .code  (state_q),
    .lines (state_line)
  );
endmodule

// File: tb/test_ctl_sequencer.sv
`timescale 1ns/1ps
module test_ctl_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_req = 1'b0;
  logic [1:0]  addr_case = 2'b00;
  logic [10:0] state_line;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  int exp_s    = 0;
  bit exp_long = 1'b0;

  always #10 clk = ~clk;

  ctl_sequencer i_ctl_sequencer (
    .clk        (clk),
    .rst        (rst),
    .run_req    (run_req),
    .addr_case  (addr_case),
    .state_line (state_line)
  );

  // step indices: 0 idle,1-3 fetch,4-6 exec,7-10 indirect
  function automatic int model_next(int s, bit run, bit [1:0] c, bit lng);
    case (s)
      0: return run ? 1 : 0;
      1: return 2;
      2: return 3;
      3: return (c == 2'b01 || c == 2'b10) ? 7 : 4;
      7: return 8;
      8: return lng ? 9 : 4;
      9: return 10;
      10: return 4;
      4: return 5;
      5: return 6;
      6: return run ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_tag(int s, bit [1:0] c);
    case (s)
      0: return "R10";
      1, 2: return "R3";
      3: case (c)
           2'b00: return "R4";
           2'b01: return "R5";
           2'b10: return "R6";
           default: return "R7";
         endcase
      7, 8, 9, 10: return "R11";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: state_line=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit run, bit [1:0] c);
    string tg;
    bit    nl;
    @(negedge clk);
    rst = r; run_req = run; addr_case = c;
    if (r) begin
      tg = "R1"; exp_s = 0; exp_long = 1'b0;
    end else begin
      tg = req_tag(exp_s, c);
      nl = (exp_s == 3) ? (c == 2'b10) : exp_long;
      exp_s = model_next(exp_s, run, c, exp_long);
      exp_long = nl;
    end
    @(posedge clk);
    #5;
    check(tg, state_line, 11'(1) << exp_s);
    n_checks++;
    if ($countones(state_line) != 1) begin
      n_fails++;
      $display("FAIL R2: state_line=%b expected one bit set", state_line);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with active inputs
    step(1, 1, 2'b10);
    step(1, 0, 2'b00);
    // R10: idle held with run low
    for (int i = 0; i < 4; i++) step(0, 0, 2'b01);
    // R3, R4: direct path, inputs toggled in fetch
    step(0, 1, 2'b00); step(0, 0, 2'b11); step(0, 0, 2'b10);
    step(0, 1, 2'b00);
    step(0, 0, 2'b01); step(0, 0, 2'b10);
    step(0, 1, 2'b00); // R9: continue to fetch
    // R5 with the code changed to 10 during the indirect steps (R11)
    step(0, 0, 2'b11); step(0, 0, 2'b00);
    step(0, 1, 2'b01);
    step(0, 1, 2'b10); step(0, 1, 2'b10);
    step(0, 1, 2'b00); step(0, 1, 2'b00);
    step(0, 0, 2'b00); // R9: back to idle
    // R6 with the code changed to 00 during the indirect steps (R11)
    step(0, 1, 2'b00); step(0, 1, 2'b00); step(0, 1, 2'b00);
    step(0, 1, 2'b10);
    for (int i = 0; i < 4; i++) step(0, 1, 2'b00);
    step(0, 1, 2'b00); step(0, 1, 2'b00); step(0, 1, 2'b01);
    // R7: case 11
    step(0, 1, 2'b00); step(0, 1, 2'b00); step(0, 1, 2'b11);
    step(0, 1, 2'b01); step(0, 1, 2'b01);
    // R1: reset in the middle of an instruction
    step(1, 1, 2'b10);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit r;
      bit run;
      r   = ($urandom % 150) == 0;
      run = ($urandom % 6) != 0;
      step(r, run, 2'($urandom % 4));
    end
    finish_run();
  end
endmodule